// File: doc/BRIEF.md
# Serial LCD Command/Data Receiver

This block is the write-only serial front end of a display controller. A host shifts bytes in on a serial clock and data line while a pair of chip selects (one active low, one active high) enables the port. Every completed byte comes out as a one-cycle strobe in the system clock domain. The strobe carries the byte value and a tag that marks it as an instruction or as display data.

A mode input picks how the tag is formed. In 4-wire mode a separate data/instruction pin gives the tag, and the pin is sampled together with the last bit of each byte. In 3-wire mode there is no such pin. An internal sequencer watches the byte stream for a display-data command followed by a two-byte length. It tags the counted run of pixel bytes that follows as data, and then goes back to tagging instructions. The serial lines are synchronized into the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `lcd_serial_rx`

## Requirements
- R1: The port is enabled only while `cs_lo_n` is 0 and `cs_hi` is 1 together; when either is inactive, any partly received byte is discarded and bits clocked in are ignored.
- R2: Bits are taken from `sdata` on rising edges of `sclk`, most significant bit first; the eighth rising edge completes a byte.
- R3: With `wire4_mode` = 1, `byte_is_data` equals the level of `dc_pin` at the eighth rising edge (1 = display data, 0 = instruction).
- R4: With `wire4_mode` = 0, bytes are tagged as instruction (`byte_is_data` = 0) until the command byte 0xFC is received; 0xFC itself is tagged as instruction.
- R5: In 3-wire mode, the two bytes after 0xFC form the 16-bit length L, low byte first and then high byte, and both are tagged as instruction.
- R6: After the length bytes, exactly 2*(L+1) bytes are tagged as display data, and the byte after them is tagged as instruction again; a length of 0xFFFF gives 131072 data bytes without wrapping.
- R7: A 0xFC byte inside a display-data run is tagged as data and does not restart the sequence.
- R8: Deselecting the port keeps the 3-wire sequencer state and its remaining count; `rst_n` = 0 returns the sequencer to idle.
- R9: `byte_vld` is high for exactly one system clock per byte, 3 system clocks after the system clock edge that first sees the eighth `sclk` rise; after reset `byte_vld` = 0 and `byte_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_lo_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| sclk | input | 1 | Serial clock (asynchronous) |
| sdata | input | 1 | Serial data, MSB first |
| dc_pin | input | 1 | Data/instruction tag, used in 4-wire mode |
| wire4_mode | input | 1 | 1 = 4-wire tagging, 0 = 3-wire in-band tagging |
| byte_vld | output | 1 | One-cycle byte strobe |
| byte_out | output | 8 | Received byte |
| byte_is_data | output | 1 | 1 = display data, 0 = instruction |

## Verification
Each byte result is due exactly 3 system clocks after the `sclk` rise that completes it. Two of those clocks are for synchronizing the line and one is for the output register. The driver notes the cycle in which it raises the eighth `sclk` edge and queues the expected value and tag. The monitor samples on the falling clock edge. It pops the queue on every strobe and checks both the payload and that the strobe came exactly 3 cycles after that edge. A strobe with nothing queued counts as a failure, so ignored traffic is checked by the absence of any output.

// File: rtl/lcd_srx_pkg.sv
package lcd_srx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LEN_LO = 2'd1,
    SEQ_LEN_HI = 2'd2,
    SEQ_RUN    = 2'd3
  } seq_state_t;

  // Index of the last data byte in a run, counting down to zero:
  // a run holds 2*(len+1) bytes, so the last index is 2*len+1.
  function automatic logic [16:0] run_last_index(input logic [15:0] len);
    return {len, 1'b1};
  endfunction

  // Shift one serial bit into the low end of a partial byte.
  function automatic logic [7:0] shift_in(input logic [7:0] acc, input logic bit_in);
    return {acc[6:0], bit_in};
  endfunction

endpackage

// File: rtl/lcd_srx_sync.sv
module lcd_srx_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = pipe[STAGES-1];
endmodule

// File: rtl/lcd_srx_shifter.sv
module lcd_srx_shifter #(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_active,
  input  logic              sclk_rise,
  input  logic              sd,
  input  logic              dc,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic              byte_dc,
  output logic [BIT_W-1:0]  bit_cnt
);
  import lcd_srx_pkg::*;

  logic [DATA_W-1:0] acc;
  logic              last_bit;

  assign last_bit  = (bit_cnt == BIT_W'(DATA_W - 1));
  assign byte_done = sel_active && sclk_rise && last_bit;
  assign byte_val  = shift_in(acc, sd);
  assign byte_dc   = dc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      bit_cnt <= '0;
    end else if (!sel_active) begin
      acc     <= '0;
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      acc     <= shift_in(acc, sd);
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_srx_seq.sv
module lcd_srx_seq #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  CMD_CODE = 8'hFC,
  localparam int         LEN_W    = 2 * DATA_W,
  localparam int         CNT_W    = LEN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wire4_mode,
  input  logic                    byte_done,
  input  logic [DATA_W-1:0]       byte_val,
  output lcd_srx_pkg::seq_state_t state,
  output logic [CNT_W-1:0]        run_left,
  output logic                    in_run
);
  import lcd_srx_pkg::*;

  logic [DATA_W-1:0] len_lo;

  assign in_run = (state == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      run_left <= '0;
      len_lo   <= '0;
    end else if (byte_done && !wire4_mode) begin
      unique case (state)
        SEQ_IDLE: begin
          if (byte_val == CMD_CODE) state <= SEQ_LEN_LO;
        end
        SEQ_LEN_LO: begin
          len_lo <= byte_val;
          state  <= SEQ_LEN_HI;
        end
        SEQ_LEN_HI: begin
          run_left <= run_last_index({byte_val, len_lo});
          state    <= SEQ_RUN;
        end
        SEQ_RUN: begin
          if (run_left == '0) state <= SEQ_IDLE;
          else                run_left <= run_left - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_serial_rx.sv
module lcd_serial_rx #(
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CMD_CODE    = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lo_n,
  input  logic              cs_hi,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              dc_pin,
  input  logic              wire4_mode,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_is_data
);
  import lcd_srx_pkg::*;

  localparam int BIT_W = $clog2(DATA_W);
  localparam int CNT_W = 2 * DATA_W + 1;
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_in, synced;
  logic             sclk_s, sclk_d, sd_s, dc_s, cs_lo_n_s, cs_hi_s;

  logic              sel_active;
  logic              sclk_rise;
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;
  logic              byte_dc;
  logic [BIT_W-1:0]  bit_cnt;
  seq_state_t        seq_state;
  logic [CNT_W-1:0]  run_left;
  logic              in_run;

  assign raw_in = {cs_lo_n, cs_hi, sclk, sdata, dc_pin};
  assign {cs_lo_n_s, cs_hi_s, sclk_s, sd_s, dc_s} = synced;

  lcd_srx_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw_in),
    .d_sync  (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise  = sclk_s && !sclk_d;
  assign sel_active = !cs_lo_n_s && cs_hi_s;

  lcd_srx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_active (sel_active),
    .sclk_rise  (sclk_rise),
    .sd         (sd_s),
    .dc         (dc_s),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .byte_dc    (byte_dc),
    .bit_cnt    (bit_cnt)
  );

  lcd_srx_seq #(.DATA_W(DATA_W), .CMD_CODE(CMD_CODE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wire4_mode (wire4_mode),
    .byte_done  (byte_done),
    .byte_val   (byte_val),
    .state      (seq_state),
    .run_left   (run_left),
    .in_run     (in_run)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_vld     <= 1'b0;
      byte_out     <= '0;
      byte_is_data <= 1'b0;
    end else begin
      byte_vld <= byte_done;
      if (byte_done) begin
        byte_out     <= byte_val;
        byte_is_data <= wire4_mode ? byte_dc : in_run;
      end
    end
  end
endmodule

// File: rtl/lcd_srx_checker.sv
module lcd_srx_checker #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3,
  parameter int CNT_W  = 17
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sel_active,
  input logic                    byte_done,
  input logic [DATA_W-1:0]       byte_val,
  input logic [BIT_W-1:0]        bit_cnt,
  input lcd_srx_pkg::seq_state_t seq_state,
  input logic [CNT_W-1:0]        run_left,
  input logic                    wire4_mode,
  input logic                    byte_vld,
  input logic                    byte_is_data
);
  import lcd_srx_pkg::*;

  assert_deselect_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> (bit_cnt == '0));

  assert_no_done_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |-> !byte_done);

  assert_wire4_holds_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wire4_mode |=> $stable(seq_state));

  assert_cmd_starts_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !wire4_mode && seq_state == SEQ_IDLE && byte_val == 8'hFC)
      |=> (seq_state == SEQ_LEN_LO));

  assert_len_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !wire4_mode && seq_state == SEQ_LEN_LO) |=> (seq_state == SEQ_LEN_HI));

  assert_run_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !wire4_mode && seq_state == SEQ_RUN && run_left == '0)
      |=> (seq_state == SEQ_IDLE));

  assert_run_tag_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !wire4_mode && seq_state == SEQ_RUN) |=> byte_is_data);

  assert_cmd_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !wire4_mode && seq_state == SEQ_RUN && run_left != '0)
      |=> (seq_state == SEQ_RUN));

  assert_seq_kept_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> $stable(seq_state));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

bind lcd_serial_rx lcd_srx_checker #(
  .DATA_W (DATA_W),
  .BIT_W  (BIT_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_active   (sel_active),
  .byte_done    (byte_done),
  .byte_val     (byte_val),
  .bit_cnt      (bit_cnt),
  .seq_state    (seq_state),
  .run_left     (run_left),
  .wire4_mode   (wire4_mode),
  .byte_vld     (byte_vld),
  .byte_is_data (byte_is_data)
);

// File: tb/sim_lcd_serial_rx.sv
module sim_lcd_serial_rx;
  localparam int EXP_LAT = 3;
  localparam int HALF    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_lo_n = 1'b1, cs_hi = 1'b0;
  logic       sclk = 1'b0, sdata = 1'b0, dc_pin = 1'b0, wire4_mode = 1'b1;
  logic       byte_vld;
  logic [7:0] byte_out;
  logic       byte_is_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [8:0] exp_q[$];
  int         due_q[$];
  string      req_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
    .sclk(sclk), .sdata(sdata), .dc_pin(dc_pin), .wire4_mode(wire4_mode),
    .byte_vld(byte_vld), .byte_out(byte_out), .byte_is_data(byte_is_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Shift nbits of val MSB first; on a full byte, queue the expectation.
  task automatic shift_bits(input logic [7:0] val, input int nbits, input logic dc,
                            input bit expect_it, input logic tag, input string req);
    for (int i = 0; i < nbits; i++) begin
      sdata  = val[7-i];
      dc_pin = (i == 7) ? dc : ~dc;
      tick(HALF);
      if (expect_it && i == 7) begin
        exp_q.push_back({tag, val});
        due_q.push_back(cyc + EXP_LAT);
        req_q.push_back(req);
      end
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] val, input logic dc, input logic tag,
                      input string req);
    shift_bits(val, 8, dc, 1'b1, tag, req);
  endtask

  task automatic select(input bit on);
    cs_lo_n = !on;
    cs_hi   = on;
    tick(HALF);
  endtask

  // Monitor: scoreboard pop on every strobe.
  always @(negedge clk) begin
    if (rst_n && byte_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected strobe", {byte_is_data, byte_out}, 0);
      end else begin
        logic [8:0] e;
        int         d;
        string      r;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        r = req_q.pop_front();
        check({byte_is_data, byte_out} == e, r, "tag/byte",
              {byte_is_data, byte_out}, e);
        check(cyc == d, "R9", "strobe cycle", cyc, d);
      end
    end
  end

  // R9: the strobe never lasts two cycles
  logic vld_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && vld_prev && byte_vld)
      check(1'b0, "R9", "strobe width", 2, 1);
    vld_prev <= byte_vld;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R9", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    check(byte_vld == 1'b0, "R9", "reset vld", byte_vld, 0);
    check(byte_out == 8'h00, "R9", "reset byte", byte_out, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 R3: 4-wire mode, tag from dc pin
    wire4_mode = 1'b1;
    select(1);
    send(8'hA5, 1'b0, 1'b0, "R3");
    send(8'h3C, 1'b1, 1'b1, "R3");
    send(8'h81, 1'b1, 1'b1, "R2");
    select(0);

    // R1: only one select active, bits ignored
    cs_lo_n = 1'b0; cs_hi = 1'b0; tick(HALF);
    shift_bits(8'hFF, 8, 1'b0, 1'b0, 1'b0, "R1");
    cs_lo_n = 1'b1; cs_hi = 1'b1; tick(HALF);
    shift_bits(8'hFF, 8, 1'b0, 1'b0, 1'b0, "R1");
    select(0);

    // R1: partial byte dropped on deselect
    select(1);
    shift_bits(8'hE0, 3, 1'b0, 1'b0, 1'b0, "R1");
    select(0);
    select(1);
    send(8'h5A, 1'b0, 1'b0, "R1");

    // 3-wire mode
    wire4_mode = 1'b0;
    send(8'h11, 1'b1, 1'b0, "R4");
    send(8'hFC, 1'b1, 1'b0, "R4");
    send(8'h02, 1'b1, 1'b0, "R5");
    send(8'h00, 1'b1, 1'b0, "R5");
    send(8'h10, 1'b0, 1'b1, "R6");
    send(8'hFC, 1'b0, 1'b1, "R7");
    send(8'h00, 1'b0, 1'b1, "R7");
    send(8'h01, 1'b0, 1'b1, "R6");
    send(8'h02, 1'b0, 1'b1, "R6");
    send(8'h03, 1'b0, 1'b1, "R6");
    send(8'h22, 1'b1, 1'b0, "R6");

    // R8: deselect mid-run keeps remaining count
    send(8'hFC, 1'b0, 1'b0, "R8");
    send(8'h00, 1'b0, 1'b0, "R8");
    send(8'h00, 1'b0, 1'b0, "R8");
    send(8'h77, 1'b0, 1'b1, "R8");
    select(0);
    select(1);
    send(8'h78, 1'b0, 1'b1, "R8");
    send(8'h79, 1'b0, 1'b0, "R8");

    // R8: reset returns sequencer to idle
    send(8'hFC, 1'b0, 1'b0, "R8");
    send(8'h05, 1'b0, 1'b0, "R8");
    send(8'h00, 1'b0, 1'b0, "R8");
    send(8'h44, 1'b0, 1'b1, "R8");
    tick(4);
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(4);
    send(8'h33, 1'b0, 1'b0, "R8");

    // R5 R6: length with nonzero high byte (L=0x0100 -> 514 data bytes)
    send(8'hFC, 1'b0, 1'b0, "R5");
    send(8'h00, 1'b0, 1'b0, "R5");
    send(8'h01, 1'b0, 1'b0, "R5");
    for (int k = 0; k < 514; k++) send(8'(k), 1'b0, 1'b1, "R6");
    send(8'h66, 1'b0, 1'b0, "R6");

    tick(10);
    check(exp_q.size() == 0, "R2", "missing strobes", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule